// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder with Vectored Acknowledge

This block collects up to 63 level-sensitive interrupt request lines and presents the most urgent one to a processor core as a 3-bit request level. A value of 7 is the most urgent level, 1 the least urgent, and 0 means nothing is pending. Sources 1 through 7 have fixed settings. Every other source has a control byte that software writes to set its level and a 3-bit rank within that level. Each source can be masked on its own, and a global mask blocks every source at once. A wake output stays high for as long as any eligible request is pending, so that power control outside the block can restart the clocks.

When the core acknowledges, the block returns an 8-bit vector that is unique to the winning source: 64 plus the source number. If no eligible request is pending, it returns the spurious vector 24. The core can acknowledge in two ways. The hardware way is a pulse on a dedicated request pin. The software way is a read of a reserved register address. Both paths share one acknowledge state machine. Its states are ACK_IDLE, ACK_RESOLVE and ACK_REPLY, with these transitions:
- ACK_IDLE goes to ACK_RESOLVE on any acknowledge request.
- ACK_RESOLVE always goes to ACK_REPLY.
- ACK_REPLY always goes back to ACK_IDLE.

Requests that arrive outside ACK_IDLE are dropped. If both request kinds arrive in the same cycle, the hardware request takes precedence. Only one register read may be outstanding at a time.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every programmable source has level 0 and rank 0, and every individual mask reads 1 (masked). The global mask reads 0, and both `ipl_o` and `wake_o` are 0.
- R2: The control byte of source n (1..63) sits at address n, with the format {2'b00, level[2:0], rank[2:0]}. A write with `reg_wr` takes effect at the next clock edge. A read pulse on `reg_rd` returns the data with `reg_rvalid` one cycle later. Index 0 reads as zero.
- R3: Source k, for k from 1 to 7, has a fixed level of k and a fixed rank of 4. Writes to its control byte are ignored, and a read returns {2'b00, k, 3'd4}.
- R4: A source is eligible when four conditions all hold: its input is high, it is unmasked, its level is nonzero, and the global mask is clear. `ipl_o` shows the level of the winning eligible source one clock after the inputs settle, or 0 if there is none. A level of 0 disables a source.
- R5: Between eligible sources, the higher level wins. At equal level, the higher rank wins. At equal level and rank, the lower source number wins.
- R6: The individual mask of source n is bit 0 at address 0x40+n, where 1 means masked. A masked source never wins and never drives the wake output.
- R7: The global mask is bit 0 at address 0x80. While it is 1, `ipl_o` is 0, `wake_o` is 0, and every acknowledge returns the spurious vector.
- R8: A one-cycle pulse on `iack_req` gives a one-cycle `iack_done` two clocks later, with `iack_vec` equal to 64 plus the number of the winning source.
- R9: A read of address 0x81 is a software acknowledge. It returns the same vector as R8 on `reg_rdata`, with `reg_rvalid` high two clocks after the read pulse.
- R10: An acknowledge with no eligible source returns vector 24.
- R11: `wake_o` is high exactly when at least one eligible request is pending, and it is registered like `ipl_o`.
- R12: Requests are not latched. Dropping an input removes that source from arbitration one clock later, and the next winner takes its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 63 | Level-sensitive request lines; bit n is source n |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid |
| ipl_o | output | 3 | Encoded request level to the core |
| wake_o | output | 1 | Eligible request pending |
| iack_req | input | 1 | Hardware acknowledge request pulse |
| iack_done | output | 1 | Hardware acknowledge reply strobe |
| iack_vec | output | 8 | Vector returned with iack_done |

## Verification
The bench raises each source on its own and checks the level and both acknowledge vectors. Any arithmetic error in the vector offset, or an off-by-one in the source index, shows up as a wrong vector. With every line raised, it then strips winners one at a time, first by masking and then by dropping inputs. This order reaches the tie between fixed source 6 and programmable source 12, where a reversed tie-break would return vector 76 instead of 70. It also reaches the point where every source is gone, where a design that latched requests or ignored masks would keep reporting a level instead of the spurious vector 24. The bench checks that writes to fixed sources change nothing. It also checks that the global mask silences both the level and the wake output, which a design that gated only one of them would fail.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef struct packed {
        logic [2:0] lvl;
        logic [2:0] pri;
    } src_cfg_t;

    typedef enum logic [1:0] {
        ACK_IDLE    = 2'd0,
        ACK_RESOLVE = 2'd1,
        ACK_REPLY   = 2'd2
    } ack_state_e;

    localparam logic [7:0] ADDR_GMASK = 8'h80;
    localparam logic [7:0] ADDR_SWACK = 8'h81;

endpackage

// File: rtl/irq_src_cfg.sv
module irq_src_cfg
    import irq_pkg::*;
#(
    parameter int NUM_SRC   = 63,
    parameter int NUM_FIXED = 7,
    parameter int FIXED_PRI = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [7:0]           addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata_o,
    output logic                 rvalid_o,
    output src_cfg_t [NUM_SRC:0] cfg_o,
    output logic [NUM_SRC:0]     mask_o,
    output logic                 mask_all_o
);

    localparam int IDX_W = 6;

    logic [IDX_W-1:0] idx;
    logic             sel_cfg;
    logic             sel_mask;
    logic             sel_glob;
    logic [7:0]       rd_d;
    logic             unused_wbits;

    assign idx          = addr[IDX_W-1:0];
    assign sel_cfg      = (addr[7:6] == 2'b00);
    assign sel_mask     = (addr[7:6] == 2'b01);
    assign sel_glob     = (addr == ADDR_GMASK);
    assign unused_wbits = &{1'b0, wdata[7:6]};

    // Per-source storage: slot 0 unused, fixed sources are constants.
    for (genvar i = 0; i <= NUM_SRC; i++) begin : g_src
        if (i == 0) begin : g_none
            assign cfg_o[i]  = '0;
            assign mask_o[i] = 1'b0;
        end else begin : g_real
            logic msk_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    msk_q <= 1'b1;
                end else if (wr_en && sel_mask && idx == IDX_W'(i)) begin
                    msk_q <= wdata[0];
                end
            end
            assign mask_o[i] = msk_q;

            if (i <= NUM_FIXED) begin : g_fixed
                assign cfg_o[i] = {3'(i), 3'(FIXED_PRI)};
            end else begin : g_prog
                src_cfg_t cfg_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        cfg_q <= '0;
                    end else if (wr_en && sel_cfg && idx == IDX_W'(i)) begin
                        cfg_q <= wdata[5:0];
                    end
                end
                assign cfg_o[i] = cfg_q;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_all_o <= 1'b0;
        end else if (wr_en && sel_glob) begin
            mask_all_o <= wdata[0];
        end
    end

    always_comb begin
        rd_d = '0;
        if (sel_cfg) begin
            rd_d = {2'b00, cfg_o[idx]};
        end else if (sel_mask) begin
            rd_d = {7'd0, mask_o[idx]};
        end else if (sel_glob) begin
            rd_d = {7'd0, mask_all_o};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_en && (addr != ADDR_SWACK);
            if (rd_en) begin
                rdata_o <= rd_d;
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC  = 63,
    parameter int VEC_BASE = 64,
    parameter int SPUR_VEC = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC:1]     req,
    input  src_cfg_t [NUM_SRC:0] cfg,
    input  logic [NUM_SRC:0]     mask,
    input  logic                 mask_all,
    output logic [2:0]           ipl_o,
    output logic                 wake_o,
    output logic [7:0]           vec_o
);

    localparam int IDX_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1] elig;
    src_cfg_t         best_key;
    logic [IDX_W-1:0] best_idx;
    logic [IDX_W-1:0] idx_q;

    for (genvar i = 1; i <= NUM_SRC; i++) begin : g_elig
        assign elig[i] = req[i] && !mask[i] && !mask_all && (cfg[i].lvl != 3'd0);
    end

    // Ascending scan; strict compare keeps the lower number on a tie.
    always_comb begin
        best_key = '0;
        best_idx = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (elig[i] && (cfg[i] > best_key)) begin
                best_key = cfg[i];
                best_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ipl_o  <= '0;
            idx_q  <= '0;
            wake_o <= 1'b0;
        end else begin
            ipl_o  <= best_key.lvl;
            idx_q  <= best_idx;
            wake_o <= |elig;
        end
    end

    assign vec_o = (idx_q == '0) ? 8'(SPUR_VEC) : 8'(VEC_BASE) + 8'(idx_q);

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_req,
    input  logic       sw_req,
    input  logic [7:0] win_vec,
    output logic       hw_done,
    output logic       sw_done,
    output logic [7:0] vec_o
);

    ack_state_e state_q;
    ack_state_e state_d;
    logic       is_hw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:    if (hw_req || sw_req) state_d = ACK_RESOLVE;
            ACK_RESOLVE: state_d = ACK_REPLY;
            ACK_REPLY:   state_d = ACK_IDLE;
            default:     state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_hw_q <= 1'b0;
            vec_o   <= '0;
        end else begin
            if (state_q == ACK_IDLE && (hw_req || sw_req)) begin
                is_hw_q <= hw_req;
            end
            if (state_q == ACK_RESOLVE) begin
                vec_o <= win_vec;
            end
        end
    end

    assign hw_done = (state_q == ACK_REPLY) && is_hw_q;
    assign sw_done = (state_q == ACK_REPLY) && !is_hw_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC   = 63,
    parameter int NUM_FIXED = 7,
    parameter int FIXED_PRI = 4,
    parameter int VEC_BASE  = 64,
    parameter int SPUR_VEC  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC:1]   irq_req,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               reg_rvalid,
    output logic [2:0]         ipl_o,
    output logic               wake_o,
    input  logic               iack_req,
    output logic               iack_done,
    output logic [7:0]         iack_vec
);

    src_cfg_t [NUM_SRC:0] cfg_w;
    logic [NUM_SRC:0]     mask_w;
    logic                 gmask;
    logic [7:0]           cfg_rdata;
    logic                 cfg_rvalid;
    logic [7:0]           win_vec;
    logic [7:0]           ack_vec;
    logic                 ack_sw_done;
    logic                 sw_req;

    assign sw_req = reg_rd && (reg_addr == ADDR_SWACK);

    irq_src_cfg #(
        .NUM_SRC   (NUM_SRC),
        .NUM_FIXED (NUM_FIXED),
        .FIXED_PRI (FIXED_PRI)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .rd_en      (reg_rd),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata_o    (cfg_rdata),
        .rvalid_o   (cfg_rvalid),
        .cfg_o      (cfg_w),
        .mask_o     (mask_w),
        .mask_all_o (gmask)
    );

    irq_arbiter #(
        .NUM_SRC  (NUM_SRC),
        .VEC_BASE (VEC_BASE),
        .SPUR_VEC (SPUR_VEC)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .cfg      (cfg_w),
        .mask     (mask_w),
        .mask_all (gmask),
        .ipl_o    (ipl_o),
        .wake_o   (wake_o),
        .vec_o    (win_vec)
    );

    irq_ack_fsm u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_req  (iack_req),
        .sw_req  (sw_req),
        .win_vec (win_vec),
        .hw_done (iack_done),
        .sw_done (ack_sw_done),
        .vec_o   (ack_vec)
    );

    assign iack_vec   = ack_vec;
    assign reg_rdata  = ack_sw_done ? ack_vec : cfg_rdata;
    assign reg_rvalid = cfg_rvalid || ack_sw_done;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ipl,
    input logic       wake,
    input logic       iack_req,
    input logic       iack_done,
    input logic [7:0] iack_vec,
    input logic       sw_done,
    input logic       mask_all
);

    p_global_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_all |=> (ipl == 3'd0 && !wake));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iack_done |=> !iack_done);

    p_hw_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iack_done |-> $past(iack_req, 2));

    p_vec_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        iack_done |-> (iack_vec == 8'd24 || (iack_vec >= 8'd65 && iack_vec <= 8'd127)));

    p_single_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iack_done, sw_done}));

    p_wake_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (ipl != 3'd0));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ipl       (ipl_o),
    .wake      (wake_o),
    .iack_req  (iack_req),
    .iack_done (iack_done),
    .iack_vec  (iack_vec),
    .sw_done   (ack_sw_done),
    .mask_all  (gmask)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:1] irq_req = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        reg_rvalid;
    logic [2:0]  ipl_o;
    logic        wake_o;
    logic        iack_req = 1'b0;
    logic        iack_done;
    logic [7:0]  iack_vec;

    int n_chk = 0;
    int n_fail = 0;

    int m_lvl [64];
    int m_pri [64];
    bit m_msk [64];
    bit m_req [64];
    bit m_g;

    always #5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .ipl_o      (ipl_o),
        .wake_o     (wake_o),
        .iack_req   (iack_req),
        .iack_done  (iack_done),
        .iack_vec   (iack_vec)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 8'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = -1;
        for (int k = 0; k < 4; k++) begin
            if (reg_rvalid) begin
                d = int'(reg_rdata);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic hw_ack(output int v);
        @(negedge clk);
        iack_req = 1'b1;
        @(negedge clk);
        iack_req = 1'b0;
        v = -1;
        for (int k = 0; k < 4; k++) begin
            if (iack_done) begin
                v = int'(iack_vec);
                break;
            end
            @(negedge clk);
        end
    endtask

    function automatic int winner();
        int best = 0;
        int bk = -1;
        for (int n = 1; n <= 63; n++) begin
            if (m_req[n] && !m_msk[n] && !m_g && m_lvl[n] > 0) begin
                if (m_lvl[n] * 8 + m_pri[n] > bk) begin
                    bk = m_lvl[n] * 8 + m_pri[n];
                    best = n;
                end
            end
        end
        return best;
    endfunction

    task automatic drive_and_settle();
        for (int n = 1; n <= 63; n++) irq_req[n] = m_req[n];
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_mask(input int n, input bit v);
        wr(64 + n, int'(v));
        m_msk[n] = v;
    endtask

    task automatic check_all(input string phase);
        int w;
        int v;
        w = winner();
        drive_and_settle();
        chk("R4", {phase, " ipl"}, int'(ipl_o), (w == 0) ? 0 : m_lvl[w]);
        chk("R11", {phase, " wake"}, int'(wake_o), (w == 0) ? 0 : 1);
        hw_ack(v);
        chk((w == 0) ? "R10" : "R8", {phase, " hw vector"}, v, (w == 0) ? 24 : 64 + w);
        rd(8'h81, v);
        chk("R9", {phase, " sw vector"}, v, (w == 0) ? 24 : 64 + w);
    endtask

    initial begin
        int d;
        int w;
        for (int n = 0; n < 64; n++) begin
            m_lvl[n] = (n >= 1 && n <= 7) ? n : 0;
            m_pri[n] = (n >= 1 && n <= 7) ? 4 : 0;
            m_msk[n] = 1'b1;
            m_req[n] = 1'b0;
        end
        m_g = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "ipl after reset", int'(ipl_o), 0);
        chk("R1", "wake after reset", int'(wake_o), 0);
        rd(10, d);  chk("R1", "ctrl of source 10", d, 0);
        rd(63, d);  chk("R1", "ctrl of source 63", d, 0);
        rd(64 + 10, d); chk("R1", "mask of source 10", d, 1);
        rd(8'h80, d); chk("R1", "global mask", d, 0);
        rd(0, d);   chk("R2", "index 0 reads zero", d, 0);

        // R3: fixed sources read fixed values, writes ignored
        for (int k = 1; k <= 7; k++) begin
            wr(k, 8'h3F);
            rd(k, d);
            chk("R3", $sformatf("fixed source %0d", k), d, k * 8 + 4);
        end

        // R2: program sources 8..63 and read them back
        for (int n = 8; n <= 63; n++) begin
            m_lvl[n] = (n == 40 || n == 63) ? 0 : (n % 7) + 1;
            m_pri[n] = n % 8;
            wr(n, m_lvl[n] * 8 + m_pri[n]);
        end
        for (int n = 8; n <= 63; n++) begin
            rd(n, d);
            chk("R2", $sformatf("readback source %0d", n), d, m_lvl[n] * 8 + m_pri[n]);
        end

        // R6/R10: all requests raised, all masked -> spurious
        for (int n = 1; n <= 63; n++) m_req[n] = 1'b1;
        check_all("R6 all masked");

        // R4/R8/R9: one source at a time, unmasked
        for (int n = 1; n <= 63; n++) set_mask(n, 1'b0);
        rd(64 + 20, d); chk("R6", "mask readback cleared", d, 0);
        for (int n = 1; n <= 63; n++) begin
            for (int j = 1; j <= 63; j++) m_req[j] = (j == n);
            check_all($sformatf("single source %0d", n));
        end

        // R5/R6: all raised, mask winners one by one
        for (int n = 1; n <= 63; n++) m_req[n] = 1'b1;
        for (int it = 0; it < 64; it++) begin
            w = winner();
            check_all($sformatf("R5 mask sweep step %0d", it));
            if (w == 0) break;
            set_mask(w, 1'b1);
        end
        for (int n = 1; n <= 63; n++) set_mask(n, 1'b0);

        // R7: global mask
        wr(8'h80, 1); m_g = 1'b1;
        check_all("R7 global set");
        rd(8'h80, d); chk("R7", "global readback", d, 1);
        wr(8'h80, 0); m_g = 1'b0;
        check_all("R7 global cleared");

        // R12: drop winners at the inputs one by one
        for (int it = 0; it < 64; it++) begin
            w = winner();
            check_all($sformatf("R12 drop step %0d", it));
            if (w == 0) break;
            m_req[w] = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule